// File: doc/BRIEF.md
# Stochastic Computing Neuron

This block is one neuron built from stochastic arithmetic. Each input and each weight is held as an 8-bit probability code. A private pseudo-random generator and a magnitude comparator turn each code into a unipolar bitstream: the stream is 1 in a cycle when the code is greater than the generator's current low byte. An AND gate multiplies each input stream by its weight stream. A multiplexer steered by a separate generator passes one product stream per cycle, which gives a scaled sum. The neuron counts the ones at the multiplexer output over a window of cycles. When the window ends it scales the count by the number of inputs and compares it with a threshold to decide whether to spike. The precision of the result depends on the window length, not on a word width.

A run begins with a one-cycle `start` pulse. That pulse captures the operands, the window code and the threshold, and clears the counters. The controller moves through three named states. IDLE waits for `start` (transition IDLE->RUN on `start`). RUN accumulates one bit per cycle and leaves when the last window cycle has been counted (RUN->DONE on window end). DONE presents `done` for one cycle and always returns to IDLE (DONE->IDLE). While in IDLE, `seed_load` reloads every generator from one base seed. Each generator mixes that base seed with its own index, so every stream starts from a different point. Reloading the same seed therefore repeats a run bit for bit.

Top module: `sc_neuron`

## Requirements
- R1: After reset `done`, `spike` and `count` are all 0 and the neuron is in IDLE.
- R2: A stream bit is 1 when its 8-bit operand is strictly greater than the low 8 bits of its generator, so an input code of 0 produces no ones and `count` ends at 0.
- R3: Each product stream is the AND of an input stream and its weight stream, so weight codes of 0 give `count` 0 even with full-scale inputs, and codes of 128 on both give about one quarter of the window.
- R4: The multiplexer selects one of the N_IN product streams per cycle, using the low log2(N_IN) bits of its own generator. With one lane at full scale and the others at 0, `count` is about window/N_IN.
- R5: `count` is the number of ones in the multiplexer output over the window. It never exceeds the window length and grows by at most 1 per cycle.
- R6: The window code `win_sel` selects the length: 0 gives 256 cycles, 1 gives 512, 2 gives 1024 and 3 gives 4096. `done` rises exactly that many clock edges after the edge that accepts `start`.
- R7: `spike` is 1 exactly when count*N_IN >= threshold, and is valid only while `done` is high.
- R8: `done` is high for one cycle. `count` is valid with it and holds its value until the next accepted `start`.
- R9: A `start` pulse that arrives while RUN is active is ignored and does not change the window timing.
- R10: Loading the same seed and running with the same operands gives an identical `count`.
- R11: An accepted `start` clears the accumulator, so a run with zero inputs after a busy run ends at `count` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run; accepted only in IDLE |
| win_sel | input | 2 | Window length code |
| thresh | input | CW+log2(N_IN) | Firing threshold for the scaled count |
| in_vec | input | N_IN*DW | Input probability codes, lane i at bits [i*DW +: DW] |
| wt_vec | input | N_IN*DW | Weight probability codes, same lane layout |
| seed_load | input | 1 | Reloads all generators from `seed`; acted on only in IDLE |
| seed | input | 16 | Base seed |
| done | output | 1 | One-cycle end-of-window pulse |
| spike | output | 1 | Fire decision, valid with `done` |
| count | output | CW | Ones counted in the last window |

## Verification
A fault in the window counter or the state register shows up at the first `done` as a window that is too short or too long, and a stuck controller shows up as a missing `done`. A generator that fails to reload, or advances outside RUN, breaks repeatability on the very next pair of runs with the same seed. A stale accumulator is exposed by the first zero-input run after a busy run. Bias in a stream, the AND or the multiplexer only appears as a `count` outside its statistical band after a full window, so those checks use wide windows and tolerant ranges.

// File: rtl/sc_neuron_pkg.sv
package sc_neuron_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } nstate_t;

    localparam int LFSR_W  = 16;
    localparam int WIN_MAX = 4096;
    localparam int CW      = $clog2(WIN_MAX + 1);
    localparam int CYW     = $clog2(WIN_MAX);

    function automatic logic [CW-1:0] win_len(input logic [1:0] sel);
        logic [CW-1:0] n;
        unique case (sel)
            2'd0: n = CW'(256);
            2'd1: n = CW'(512);
            2'd2: n = CW'(1024);
            default: n = CW'(4096);
        endcase
        return n;
    endfunction

    function automatic logic [LFSR_W-1:0] lane_seed(input logic [LFSR_W-1:0] base,
                                                    input int idx);
        logic [LFSR_W-1:0] s;
        s = base ^ LFSR_W'((32'(idx) + 32'd1) * 32'h0000_9E37);
        if (s == '0) s = LFSR_W'(1);
        return s;
    endfunction

endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
    parameter int                W       = 16,
    parameter logic [W-1:0]      TAPS    = 16'hB400,
    parameter logic [W-1:0]      RST_VAL = 16'h0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         adv,
    output logic [W-1:0] state_o
);
    logic [W-1:0] st;
    logic [W-1:0] nxt;

    // Galois form: shift right, fold feedback into the tap positions
    always_comb begin
        nxt = {1'b0, st[W-1:1]} ^ (st[0] ? TAPS : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st <= RST_VAL;
        else if (load) st <= seed;
        else if (adv)  st <= nxt;
    end

    assign state_o = st;
endmodule

// File: rtl/sc_bitstream.sv
module sc_bitstream
    import sc_neuron_pkg::*;
#(
    parameter int               DW       = 8,
    parameter int               IDX      = 0,
    parameter logic [LFSR_W-1:0] DEF_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] base_seed,
    input  logic              adv,
    input  logic [DW-1:0]     code,
    output logic              bit_o
);
    localparam logic [LFSR_W-1:0] RST_SEED = lane_seed(DEF_SEED, IDX);

    logic [LFSR_W-1:0] rnd;
    logic [LFSR_W-1:0] my_seed;

    assign my_seed = lane_seed(base_seed, IDX);

    sc_lfsr #(
        .W       (LFSR_W),
        .TAPS    (16'hB400),
        .RST_VAL (RST_SEED)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .seed    (my_seed),
        .adv     (adv),
        .state_o (rnd)
    );

    assign bit_o = (code > rnd[DW-1:0]);
endmodule

// File: rtl/sc_window_acc.sv
module sc_window_acc
    import sc_neuron_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic           bit_i,
    input  logic [CYW-1:0] last_i,
    output logic [CW-1:0]  acc_o,
    output logic           end_o
);
    logic [CW-1:0]  acc;
    logic [CYW-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            cyc <= '0;
        end else if (clr) begin
            acc <= '0;
            cyc <= '0;
        end else if (en) begin
            acc <= acc + CW'(bit_i);
            cyc <= cyc + CYW'(1);
        end
    end

    assign acc_o = acc;
    assign end_o = en && (cyc == last_i);
endmodule

// File: rtl/sc_neuron.sv
module sc_neuron
    import sc_neuron_pkg::*;
#(
    parameter int                N_IN     = 4,
    parameter int                DW       = 8,
    parameter logic [LFSR_W-1:0] DEF_SEED = 16'hACE1,
    localparam int               SELW     = $clog2(N_IN),
    localparam int               SW       = CW + SELW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         win_sel,
    input  logic [SW-1:0]      thresh,
    input  logic [N_IN*DW-1:0] in_vec,
    input  logic [N_IN*DW-1:0] wt_vec,
    input  logic               seed_load,
    input  logic [15:0]        seed,
    output logic               done,
    output logic               spike,
    output logic [CW-1:0]      count
);
    nstate_t state, state_nx;

    logic [N_IN*DW-1:0] in_q, wt_q;
    logic [1:0]         ws_q;
    logic [SW-1:0]      thresh_q;

    logic               accept, running, gen_load;
    logic [N_IN-1:0]    in_bits, wt_bits, prod;
    logic [LFSR_W-1:0]  sel_rnd;
    logic [SELW-1:0]    sel;
    logic               mux_bit;
    logic [CW-1:0]      acc;
    logic               win_end;
    logic [CYW-1:0]     last_cyc;
    logic [SW-1:0]      scaled;

    assign accept   = (state == ST_IDLE) && start;
    assign running  = (state == ST_RUN);
    assign gen_load = (state == ST_IDLE) && seed_load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)   state_nx = ST_RUN;
            ST_RUN:  if (win_end) state_nx = ST_DONE;
            ST_DONE:              state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    // run parameters captured when a start is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q     <= '0;
            wt_q     <= '0;
            ws_q     <= '0;
            thresh_q <= '0;
        end else if (accept) begin
            in_q     <= in_vec;
            wt_q     <= wt_vec;
            ws_q     <= win_sel;
            thresh_q <= thresh;
        end
    end

    genvar i;
    generate
        for (i = 0; i < N_IN; i++) begin : g_lane
            sc_bitstream #(.DW(DW), .IDX(i), .DEF_SEED(DEF_SEED)) u_in (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (gen_load),
                .base_seed (seed),
                .adv       (running),
                .code      (in_q[i*DW +: DW]),
                .bit_o     (in_bits[i])
            );
            sc_bitstream #(.DW(DW), .IDX(N_IN + i), .DEF_SEED(DEF_SEED)) u_wt (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (gen_load),
                .base_seed (seed),
                .adv       (running),
                .code      (wt_q[i*DW +: DW]),
                .bit_o     (wt_bits[i])
            );
            assign prod[i] = in_bits[i] & wt_bits[i];
        end
    endgenerate

    sc_lfsr #(
        .W       (LFSR_W),
        .TAPS    (16'hB400),
        .RST_VAL (lane_seed(DEF_SEED, 2 * N_IN))
    ) u_sel_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gen_load),
        .seed    (lane_seed(seed, 2 * N_IN)),
        .adv     (running),
        .state_o (sel_rnd)
    );

    assign sel     = sel_rnd[SELW-1:0];
    assign mux_bit = prod[sel];

    assign last_cyc = CYW'(win_len(ws_q) - CW'(1));

    sc_window_acc u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .en     (running),
        .bit_i  (mux_bit),
        .last_i (last_cyc),
        .acc_o  (acc),
        .end_o  (win_end)
    );

    assign scaled = SW'(acc) << SELW;

    // outputs
    always_comb begin
        done  = (state == ST_DONE);
        spike = done && (scaled >= thresh_q);
        count = acc;
    end
endmodule

// File: rtl/sc_neuron_chk.sv
module sc_neuron_chk
    import sc_neuron_pkg::*;
#(
    parameter int N_IN = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          spike,
    input logic [CW-1:0] count,
    input nstate_t       state,
    input logic [1:0]    ws_q
);
    logic [CW:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  run_cnt <= '0;
        else if (state == ST_IDLE)   run_cnt <= '0;
        else if (state == ST_RUN)    run_cnt <= run_cnt + 1'b1;
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == {1'b0, win_len(ws_q)}));

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (count == '0));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (count == $past(count) || count == $past(count) + 1'b1));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && !(state == ST_IDLE && start)) |=> $stable(count));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start) |=> (state != ST_IDLE));

    assert_spike_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spike |-> done);
endmodule

bind sc_neuron sc_neuron_chk #(.N_IN(N_IN)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .spike (spike),
    .count (count),
    .state (state),
    .ws_q  (ws_q)
);

// File: tb/sim_sc_neuron.sv
`timescale 1ns/1ps
module sim_sc_neuron;
    localparam int N_IN = 4;
    localparam int DW   = 8;
    localparam int CW   = 13;
    localparam int SW   = 15;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         win_sel = 2'd0;
    logic [SW-1:0]      thresh = '0;
    logic [N_IN*DW-1:0] in_vec = '0;
    logic [N_IN*DW-1:0] wt_vec = '0;
    logic               seed_load = 1'b0;
    logic [15:0]        seed = 16'h0;
    logic               done, spike;
    logic [CW-1:0]      count;

    int nchk = 0;
    int nfail = 0;
    int r_cyc, r_cnt;
    bit r_spk;

    always #5 clk = ~clk;

    sc_neuron #(.N_IN(N_IN), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .win_sel(win_sel),
        .thresh(thresh), .in_vec(in_vec), .wt_vec(wt_vec),
        .seed_load(seed_load), .seed(seed),
        .done(done), .spike(spike), .count(count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_all(input int iv, input int wv);
        for (int k = 0; k < N_IN; k++) begin
            in_vec[k*DW +: DW] = DW'(iv);
            wt_vec[k*DW +: DW] = DW'(wv);
        end
    endtask

    task automatic load_seed(input int s);
        @(negedge clk);
        seed = 16'(s);
        seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    // starts a run and waits for done; optional second start inside the window
    task automatic run(input int ws, input int th, input int restart_at);
        win_sel = 2'(ws);
        thresh = SW'(th);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_cyc = 0;
        forever begin
            @(negedge clk);
            r_cyc++;
            start = (r_cyc == restart_at);
            if (done) break;
            if (r_cyc > 5000) begin
                chk(1'b0, "run timeout", r_cyc, 0);
                break;
            end
        end
        start = 1'b0;
        r_spk = spike;
        r_cnt = int'(count);
    endtask

    task automatic t_reset();
        chk(done == 1'b0,  "R1 done after reset",  int'(done),  0);
        chk(spike == 1'b0, "R1 spike after reset", int'(spike), 0);
        chk(count == '0,   "R1 count after reset", int'(count), 0);
    endtask

    task automatic t_zero_input();
        set_all(0, 255);
        run(0, 0, -1);
        chk(r_cyc == 256, "R6 window code 0 length", r_cyc, 256);
        chk(r_cnt == 0,   "R2 zero input count",     r_cnt, 0);
        chk(r_spk == 1'b1,"R7 threshold 0 fires",    int'(r_spk), 1);
        run(0, 1, -1);
        chk(r_spk == 1'b0,"R7 threshold 1 with count 0", int'(r_spk), 0);
    endtask

    task automatic t_zero_weight();
        set_all(255, 0);
        run(1, 0, -1);
        chk(r_cyc == 512, "R6 window code 1 length", r_cyc, 512);
        chk(r_cnt == 0,   "R3 zero weight count",    r_cnt, 0);
    endtask

    task automatic t_full_scale();
        set_all(255, 255);
        run(0, 32767, -1);
        chk(r_cnt >= 240 && r_cnt <= 256, "R5 full scale count in [240,256]", r_cnt, 254);
        chk(r_spk == 1'b0, "R7 unreachable threshold", int'(r_spk), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done lasts one cycle", int'(done), 0);
        repeat (5) @(negedge clk);
        chk(int'(count) == r_cnt, "R8 count holds after done", int'(count), r_cnt);
    endtask

    task automatic t_clear();
        set_all(0, 0);
        run(0, 0, -1);
        chk(r_cnt == 0, "R11 count cleared by start", r_cnt, 0);
    endtask

    task automatic t_mux_one_lane();
        set_all(0, 0);
        in_vec[0 +: DW] = 8'd255;
        wt_vec[0 +: DW] = 8'd255;
        run(2, 0, -1);
        chk(r_cyc == 1024, "R6 window code 2 length", r_cyc, 1024);
        chk(r_cnt >= 200 && r_cnt <= 310, "R4 one lane gives window/4", r_cnt, 254);
    endtask

    task automatic t_rates();
        set_all(128, 255);
        run(3, 0, -1);
        chk(r_cyc == 4096, "R6 window code 3 length", r_cyc, 4096);
        chk(r_cnt >= 1850 && r_cnt <= 2250, "R2 half rate stream", r_cnt, 2048);
        set_all(128, 128);
        run(3, 0, -1);
        chk(r_cnt >= 850 && r_cnt <= 1200, "R3 product of two half streams", r_cnt, 1024);
    endtask

    task automatic t_repeat();
        int c1;
        set_all(200, 150);
        load_seed(16'h1234);
        run(0, 0, -1);
        c1 = r_cnt;
        chk(c1 > 0, "R10 reference run nonzero", c1, 1);
        load_seed(16'h1234);
        run(0, c1 * N_IN, -1);
        chk(r_cnt == c1, "R10 same seed same count", r_cnt, c1);
        chk(r_spk == 1'b1, "R7 threshold equal to scaled count fires", int'(r_spk), 1);
        load_seed(16'h1234);
        run(0, c1 * N_IN + 1, -1);
        chk(r_spk == 1'b0, "R7 threshold one above scaled count", int'(r_spk), 0);
    endtask

    task automatic t_restart();
        set_all(255, 255);
        run(0, 0, 50);
        chk(r_cyc == 256, "R9 start during run ignored", r_cyc, 256);
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_zero_input();
        t_zero_weight();
        t_full_scale();
        t_clear();
        t_mux_one_lane();
        t_rates();
        t_repeat();
        t_restart();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule